// File: doc/BRIEF.md
# TDM Quadrant Bit-Forcing Unit

This unit sits in the receive path of a multi-stream time-division switch. Each incoming 8-bit channel sample carries a stream number and a channel index. The unit works out which quarter of the frame the channel belongs to and then applies that stream's setting for that quarter. The setting either passes the sample through or forces its least or most significant bit to a fixed level. A rate selector sets the frame length in channels, so the quarter boundaries move with the rate.

Software holds one control word per stream through a small register port. Writes are synchronous and reads are combinational. The sample path has one register stage. Serialisation, switching memory and clock generation are outside this unit.

Top module: `tdm_qforce_top`

## Requirements
- R1: After reset, every stream control word reads 0 and `outValid` is low.
- R2: Stream n's control word sits at address `BASE_ADDR + n`. A read returns the stored bits 11:0, and bits 15:12 always read 0. An access to any other address reads 0, and a write there changes no stored word. The quarter fields are bits 2:0 for quarter 0, 5:3 for quarter 1, 8:6 for quarter 2 and 11:9 for quarter 3.
- R3: `rateSel` values 0, 1, 2 and 3 select frames of 32, 64, 128 and 256 channels. The quarter is channel index bits [4+rateSel:3+rateSel].
- R4: A quarter code with bit 2 clear (0xx) leaves the sample unchanged.
- R5: Code 100 forces data bit 0 to 0, and code 101 forces it to 1. No other data bit changes.
- R6: Code 110 forces data bit 7 to 0, and code 111 forces it to 1. No other data bit changes.
- R7: `outValid` equals `inValid` from one clock earlier. A valid output carries the stream number and channel index of that input unchanged.
- R8: A sample presented in the same cycle as a write uses the old word. The next sample uses the new word.
- R9: Channel index bits above the selected frame width play no part in choosing the quarter.
- R10: Each stream uses only its own control word. A write to one stream does not alter the treatment of another stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data for `regAddr` (combinational) |
| rateSel | input | RATE_W | Frame length select: 0=32, 1=64, 2=128, 3=256 channels |
| inValid | input | 1 | Input sample valid |
| inStream | input | STREAM_W | Input stream number |
| inChan | input | CH_W | Input channel index |
| inData | input | DATA_W | Input sample |
| outValid | output | 1 | Output sample valid |
| outStream | output | STREAM_W | Stream number of the output sample |
| outChan | output | CH_W | Channel index of the output sample |
| outData | output | DATA_W | Output sample after forcing |

## Verification
The bench builds the unit with four streams and keeps the full 8-bit channel index and all four rates. With that setting, every channel index of every rate can be driven through every stream. Eight rounds of control words rotate each quarter of each stream through all eight codes. This reaches every combination of rate, quarter and code, and it also reaches the channel indices above the frame that R9 covers. The small stream count also lets the bench probe both sides of the address window.

// File: rtl/tdm_qforce_pkg.sv
package tdm_qforce_pkg;
  localparam int CTRL_W = 16;
  localparam int QUADS  = 4;
  localparam int CODE_W = 3;
  localparam int USED_W = QUADS * CODE_W;
  localparam int IDX_W  = 8;

  // Strobes passed from the register decoder to the storage and datapath side
  typedef struct packed {
    logic              wrStb;
    logic              rdHit;
    logic [IDX_W-1:0]  idx;
    logic [USED_W-1:0] wrField;
  } regStrobe_t;
endpackage

// File: rtl/tdm_qforce_ctrl.sv
module tdm_qforce_ctrl
  import tdm_qforce_pkg::*;
#(
  parameter int STREAMS = 32,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0120
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CTRL_W-1:0] regWrData,
  output regStrobe_t        strobe
);
  logic [ADDR_W-1:0] offset;
  logic              inWindow;
  logic              unusedRsvd;

  assign unusedRsvd = ^regWrData[CTRL_W-1:USED_W];

  always_comb begin
    offset   = regAddr - BASE_ADDR;
    inWindow = (regAddr >= BASE_ADDR) && (offset < ADDR_W'(STREAMS));
    strobe.rdHit   = inWindow;
    strobe.wrStb   = inWindow && regWrEn;
    strobe.idx     = offset[IDX_W-1:0];
    strobe.wrField = regWrData[USED_W-1:0];
  end
endmodule

// File: rtl/tdm_qforce_regs.sv
module tdm_qforce_regs
  import tdm_qforce_pkg::*;
#(
  parameter int STREAMS = 32,
  localparam int STREAM_W = $clog2(STREAMS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  logic [STREAM_W-1:0] lkStream,
  output logic [USED_W-1:0]   lkWord,
  output logic [CTRL_W-1:0]   rdData
);
  logic [USED_W-1:0] bank [STREAMS];
  logic [STREAM_W-1:0] rdIdx;
  logic unusedHi;

  for (genvar s = 0; s < STREAMS; s++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN)
        bank[s] <= '0;
      else if (strobe.wrStb && (strobe.idx == IDX_W'(s)))
        bank[s] <= strobe.wrField;
    end
  end

  assign rdIdx    = STREAM_W'(strobe.idx);
  assign unusedHi = |(strobe.idx >> STREAM_W);

  always_comb begin
    lkWord = bank[lkStream];
    rdData = '0;
    if (strobe.rdHit)
      rdData = {{(CTRL_W-USED_W){1'b0}}, bank[rdIdx]};
  end
endmodule

// File: rtl/tdm_qforce_dp.sv
module tdm_qforce_dp
  import tdm_qforce_pkg::*;
#(
  parameter int STREAM_W = 5,
  parameter int CH_W = 8,
  parameter int MIN_CH_W = 5,
  parameter int DATA_W = 8,
  localparam int RATE_W = $clog2(CH_W - MIN_CH_W + 1),
  localparam int SH_W = $clog2(CH_W) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [RATE_W-1:0]   rateSel,
  input  logic                inValid,
  input  logic [STREAM_W-1:0] inStream,
  input  logic [CH_W-1:0]     inChan,
  input  logic [DATA_W-1:0]   inData,
  input  logic [USED_W-1:0]   ctrlWord,
  output logic                outValid,
  output logic [STREAM_W-1:0] outStream,
  output logic [CH_W-1:0]     outChan,
  output logic [DATA_W-1:0]   outData
);
  logic [SH_W-1:0]   shiftAmt;
  logic [1:0]        quad;
  logic [CODE_W-1:0] code;
  logic [DATA_W-1:0] forced;

  always_comb begin
    shiftAmt = SH_W'(MIN_CH_W - 2) + SH_W'(rateSel);
    quad     = 2'(inChan >> shiftAmt);
    code     = ctrlWord[quad*CODE_W +: CODE_W];
    forced   = inData;
    if (code[2]) begin
      if (code[1]) forced[DATA_W-1] = code[0];
      else         forced[0]        = code[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outStream <= '0;
      outChan   <= '0;
      outData   <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outStream <= inStream;
        outChan   <= inChan;
        outData   <= forced;
      end
    end
  end
endmodule

// File: rtl/tdm_qforce_top.sv
module tdm_qforce_top
  import tdm_qforce_pkg::*;
#(
  parameter int STREAMS = 32,
  parameter int DATA_W = 8,
  parameter int CH_W = 8,
  parameter int MIN_CH_W = 5,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0120,
  localparam int STREAM_W = $clog2(STREAMS),
  localparam int RATE_W = $clog2(CH_W - MIN_CH_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [15:0]         regWrData,
  output logic [15:0]         regRdData,
  input  logic [RATE_W-1:0]   rateSel,
  input  logic                inValid,
  input  logic [STREAM_W-1:0] inStream,
  input  logic [CH_W-1:0]     inChan,
  input  logic [DATA_W-1:0]   inData,
  output logic                outValid,
  output logic [STREAM_W-1:0] outStream,
  output logic [CH_W-1:0]     outChan,
  output logic [DATA_W-1:0]   outData
);
  regStrobe_t        strobe;
  logic [USED_W-1:0] ctrlWord;

  tdm_qforce_ctrl #(.STREAMS(STREAMS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) ctrl_i (
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .strobe(strobe)
  );

  tdm_qforce_regs #(.STREAMS(STREAMS)) regs_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lkStream(inStream),
    .lkWord(ctrlWord), .rdData(regRdData)
  );

  tdm_qforce_dp #(.STREAM_W(STREAM_W), .CH_W(CH_W), .MIN_CH_W(MIN_CH_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .inValid(inValid), .inStream(inStream),
    .inChan(inChan), .inData(inData), .ctrlWord(ctrlWord), .outValid(outValid),
    .outStream(outStream), .outChan(outChan), .outData(outData)
  );
endmodule

// File: rtl/tdm_qforce_chk.sv
module tdm_qforce_chk #(
  parameter int STREAM_W = 5,
  parameter int CH_W = 8,
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [STREAM_W-1:0] inStream,
  input logic [CH_W-1:0]     inChan,
  input logic [DATA_W-1:0]   inData,
  input logic                outValid,
  input logic [STREAM_W-1:0] outStream,
  input logic [CH_W-1:0]     outChan,
  input logic [DATA_W-1:0]   outData,
  input logic [15:0]         regRdData
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R7
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R7
  AST_TAG_CARRIED: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outStream == $past(inStream)) && (outChan == $past(inChan))); // R7
  AST_MIDDLE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outData[DATA_W-2:1] == $past(inData[DATA_W-2:1])); // R5
  AST_ONE_BIT_AT_MOST: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> $countones(outData ^ $past(inData)) <= 1); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[15:12] == 4'b0); // R2
endmodule

bind tdm_qforce_top tdm_qforce_chk #(.STREAM_W(STREAM_W), .CH_W(CH_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inStream(inStream), .inChan(inChan),
  .inData(inData), .outValid(outValid), .outStream(outStream), .outChan(outChan),
  .outData(outData), .regRdData(regRdData)
);

// File: tb/tdm_qforce_top_tb_top.sv
module tdm_qforce_top_tb_top;
  localparam int STREAMS = 4;
  localparam int STREAM_W = 2;
  localparam int CH_W = 8;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;
  localparam logic [15:0] BASE = 16'h0120;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [1:0] rateSel = '0;
  logic inValid = 1'b0;
  logic [STREAM_W-1:0] inStream = '0;
  logic [CH_W-1:0] inChan = '0;
  logic [DATA_W-1:0] inData = '0;
  logic outValid;
  logic [STREAM_W-1:0] outStream;
  logic [CH_W-1:0] outChan;
  logic [DATA_W-1:0] outData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [11:0] model [STREAMS];
  int rateCur = 0;

  always #10 clk = ~clk;

  tdm_qforce_top #(.STREAMS(STREAMS), .DATA_W(DATA_W), .CH_W(CH_W), .MIN_CH_W(5),
                   .ADDR_W(ADDR_W), .BASE_ADDR(BASE)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .rateSel(rateSel), .inValid(inValid), .inStream(inStream),
    .inChan(inChan), .inData(inData), .outValid(outValid), .outStream(outStream),
    .outChan(outChan), .outData(outData)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int expData(int d, int ch, int rate, int w);
    int q, code, r;
    q = (ch >> (3 + rate)) & 3;
    code = (w >> (3 * q)) & 7;
    r = d;
    if (code >= 6) r = (d & 8'h7F) | ((code & 1) << 7);
    else if (code >= 4) r = (d & 8'hFE) | (code & 1);
    return r;
  endfunction

  function automatic string tagFor(int ch, int rate, int w);
    int code;
    code = (w >> (3 * ((ch >> (3 + rate)) & 3))) & 7;
    if (ch >= (32 << rate)) return "R9";
    if (code >= 6) return "R6";
    if (code >= 4) return "R5";
    return "R4";
  endfunction

  task automatic writeReg(int addr, int data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = ADDR_W'(addr); regWrData = 16'(data);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(int addr, output int rd);
    @(negedge clk);
    regAddr = ADDR_W'(addr);
    #1 rd = int'(regRdData);
  endtask

  task automatic sendOne(int s, int ch, int d);
    string msg;
    @(negedge clk);
    inValid = 1'b1; inStream = STREAM_W'(s); inChan = CH_W'(ch); inData = DATA_W'(d);
    @(negedge clk);
    inValid = 1'b0;
    msg = $sformatf("R3/R10 rate%0d s%0d ch%0d", rateCur, s, ch);
    check("R7", {msg, " valid"}, int'(outValid), 1);
    check("R7", {msg, " stream"}, int'(outStream), s);
    check("R7", {msg, " chan"}, int'(outChan), ch);
    check(tagFor(ch, rateCur, int'(model[s])), {msg, " data"}, int'(outData),
          expData(d, ch, rateCur, int'(model[s])));
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    int rd, w;
    for (int s = 0; s < STREAMS; s++) model[s] = '0;
    repeat (3) @(negedge clk);
    check("R1", "outValid in reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "outValid after reset", int'(outValid), 0);
    for (int s = 0; s < STREAMS; s++) begin
      readReg(BASE + s, rd);
      check("R1", $sformatf("reset word s%0d", s), rd, 0);
    end

    // R2: readback masks reserved bits
    for (int s = 0; s < STREAMS; s++) begin
      w = 16'hF000 | ((s * 16'h111 + 16'h0A5) & 16'hFFF);
      writeReg(BASE + s, w);
      model[s] = 12'(w);
      readReg(BASE + s, rd);
      check("R2", $sformatf("readback s%0d", s), rd, w & 16'h0FFF);
    end
    // R2: addresses outside the window
    writeReg(BASE + STREAMS, 16'hFFFF);
    writeReg(BASE - 1, 16'hFFFF);
    readReg(BASE + STREAMS, rd);
    check("R2", "read above window", rd, 0);
    readReg(BASE - 1, rd);
    check("R2", "read below window", rd, 0);
    for (int s = 0; s < STREAMS; s++) begin
      readReg(BASE + s, rd);
      check("R2", $sformatf("untouched s%0d", s), rd, int'(model[s]));
    end

    // R3 R4 R5 R6 R9 R10: rotate all codes through every quarter and stream
    for (int base = 0; base < 8; base++) begin
      for (int s = 0; s < STREAMS; s++) begin
        w = 0;
        for (int q = 0; q < 4; q++) w |= ((base + s + 2 * q) % 8) << (3 * q);
        writeReg(BASE + s, w);
        model[s] = 12'(w);
      end
      for (int rate = 0; rate < 4; rate++) begin
        @(negedge clk);
        rateSel = 2'(rate);
        rateCur = rate;
        for (int s = 0; s < STREAMS; s++)
          for (int ch = 0; ch < 256; ch++)
            sendOne(s, ch, (ch * 37 + s * 11 + base * 5 + 8'h5A) & 8'hFF);
      end
    end

    // R7: back-to-back samples, then idle
    writeReg(BASE + 0, 12'o0000);
    model[0] = '0;
    @(negedge clk);
    rateSel = 2'd0; rateCur = 0;
    inValid = 1'b1; inStream = 2'd0; inChan = 8'd3; inData = 8'hC3;
    @(negedge clk);
    check("R7", "b2b first data", int'(outData), 8'hC3);
    check("R7", "b2b first chan", int'(outChan), 3);
    inStream = 2'd3; inChan = 8'd30; inData = 8'h81;
    @(negedge clk);
    check("R7", "b2b second valid", int'(outValid), 1);
    check("R7", "b2b second stream", int'(outStream), 3);
    check("R7", "b2b second data", int'(outData), expData(8'h81, 30, 0, int'(model[3])));
    inValid = 1'b0;
    @(negedge clk);
    check("R7", "idle valid", int'(outValid), 0);

    // R8: write and sample in the same cycle
    writeReg(BASE + 2, 12'o4444);
    model[2] = 12'o4444;
    @(negedge clk);
    regWrEn = 1'b1; regAddr = BASE + 2; regWrData = 16'h0B6D;
    inValid = 1'b1; inStream = 2'd2; inChan = 8'd0; inData = 8'h00;
    @(negedge clk);
    regWrEn = 1'b0;
    check("R8", "same-cycle sample uses old word", int'(outData), 8'h00);
    @(negedge clk);
    inValid = 1'b0;
    check("R8", "next sample uses new word", int'(outData), 8'h01);

    done = 1'b1;
    finishRun();
  end
endmodule